// File: doc/BRIEF.md
# Maskable repeating RTC alarm

This block is the alarm comparator of a BCD real-time clock. Software programs four byte-wide alarm registers: seconds, minutes, hours and day of month. Each register holds a BCD value in its low bits and a repeat mask in bit 7. The running BCD time from the timekeeping counters is compared against the registers on every seconds tick. A one-clock interrupt pulse is raised when every field that takes part in the comparison matches.

The pattern of mask bits sets the repeat rate. With no masks set, all four fields are compared and the alarm repeats monthly. Masking the day gives a daily alarm. Masking the day and the hour gives an hourly alarm. Masking the day, hour and minute gives an alarm once a minute. Masking all four fires on every tick. Any other mask pattern also fires on every tick.

Writes are range-checked. A seconds or minutes value outside BCD 00..59 is dropped, and so is an hours value outside 00..23. Reads return each register exactly as it was stored.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset all four alarm registers read 0x00 and irq_o is low.
- R2: A write at addr_i stores the full wdata_i byte, and rdata_o shows the register selected by addr_i unchanged. The addresses are 0 = seconds, 1 = minutes, 2 = hours and 3 = day of month, with bit 7 of each register as its mask bit.
- R3: A seconds or minutes write is accepted only when wdata_i[3:0] <= 9 and wdata_i[6:4] <= 5. Any other such write leaves the register unchanged.
- R4: An hours write is accepted only when wdata_i[3:0] <= 9 and the BCD value of wdata_i[5:0] is <= 23. Any other such write leaves the register unchanged.
- R5: A day-of-month write is always accepted.
- R6: With all mask bits clear, a tick fires only when seconds (bits 6:0), minutes (6:0), hours (5:0) and day (4:0) all equal the time inputs.
- R7: With only the day mask set, the day field is ignored and seconds, minutes and hours must match.
- R8: With the day and hour masks set, only seconds and minutes must match.
- R9: With the day, hour and minute masks set, only seconds must match.
- R10: With all four masks set, every tick fires.
- R11: Any other mask pattern fires on every tick.
- R12: irq_o is high for exactly the one clock after a cycle with tick_i high whose time inputs match. It never rises without a tick, even when a register write creates a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the selected register |
| tick_i | input | 1 | One-cycle seconds tick; the time inputs are valid with it |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD |
| day_i | input | 5 | Current day of month, BCD |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
Each repeat mode is driven with one tick whose time matches every compared field. It is then driven with ticks that differ in exactly one field. This separates a field that the mode must compare from one it must ignore, for example a day mismatch that fires in daily mode but not in monthly mode. Write checks use values that fail only on the units digit or only on the tens digit, so the checks show whether validation looks at both digits. A mixed mask pattern and idle cycles after a matching write show that unlisted patterns fire on every tick and that nothing fires between ticks.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD   = 4;
  localparam int DATA_W   = 8;
  localparam int MASK_BIT = DATA_W - 1;
  localparam int ADDR_W   = $clog2(NFIELD);

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_e;

  // bits of each field taking part in the compare
  function automatic logic [DATA_W-1:0] field_mask(int idx);
    case (idx)
      0, 1:    field_mask = 8'h7F;
      2:       field_mask = 8'h3F;
      default: field_mask = 8'h1F;
    endcase
  endfunction

  function automatic logic field_ok(int idx, logic [DATA_W-1:0] v);
    logic [5:0] val;
    val = 6'(v[5:4]) * 6'd10 + 6'(v[3:0]);
    case (idx)
      0, 1:    field_ok = (v[3:0] <= 4'd9) && (v[6:4] <= 3'd5);
      2:       field_ok = (v[3:0] <= 4'd9) && (val <= 6'd23);
      default: field_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int DW = DATA_W,
  localparam int AW = $clog2(NF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NF-1:0][DW-1:0]  regs_o
);
  logic [NF-1:0][DW-1:0] regs_q;
  logic [NF-1:0]         accept;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign accept[i] = wr_en_i && (addr_i == AW'(i)) && field_ok(i, wdata_i);

    AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(i) && !accept[i]) |=> (regs_q[i] == $past(regs_q[i]))); // R3
    AST_ACCEPT_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept[i] |=> (regs_q[i] == $past(wdata_i))); // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (accept[i]) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];
  assign regs_o  = regs_q;
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int DW = DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NF-1:0][DW-1:0] regs_i,
  input  logic [NF-1:0][DW-1:0] now_i,
  output rpt_e                  mode_o,
  output logic                  match_o
);
  logic [NF-1:0] eq;
  logic [3:0]    masks;

  for (genvar i = 0; i < NF; i++) begin : g_eq
    assign eq[i] = ((regs_i[i] ^ now_i[i]) & field_mask(i)) == '0;
  end

  assign masks = {regs_i[3][MASK_BIT], regs_i[2][MASK_BIT],
                  regs_i[1][MASK_BIT], regs_i[0][MASK_BIT]};

  always_comb begin
    case (masks)
      4'b0000: mode_o = RPT_MONTH;
      4'b1000: mode_o = RPT_DAY;
      4'b1100: mode_o = RPT_HOUR;
      4'b1110: mode_o = RPT_MIN;
      default: mode_o = RPT_SEC; // includes unlisted patterns
    endcase
  end

  always_comb begin
    case (mode_o)
      RPT_MONTH: match_o = &eq;
      RPT_DAY:   match_o = &eq[2:0];
      RPT_HOUR:  match_o = &eq[1:0];
      RPT_MIN:   match_o = eq[0];
      default:   match_o = 1'b1;
    endcase
  end

  AST_MONTH_DAY_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == RPT_MONTH && match_o) |-> (regs_i[3][4:0] == now_i[3][4:0])); // R6
  AST_SEC_COMPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != RPT_SEC && match_o) |-> (regs_i[0][6:0] == now_i[0][6:0])); // R9
  AST_ALL_MASK_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masks == 4'b1111) |-> match_o); // R10
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= tick_i && match_i;
  end

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i)); // R12
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tick_i,
  input  logic [6:0] sec_i,
  input  logic [6:0] min_i,
  input  logic [5:0] hour_i,
  input  logic [4:0] day_i,
  output logic       irq_o
);
  logic [NFIELD-1:0][DATA_W-1:0] regs;
  logic [NFIELD-1:0][DATA_W-1:0] now;
  rpt_e mode;
  logic match;

  assign now[0] = DATA_W'(sec_i);
  assign now[1] = DATA_W'(min_i);
  assign now[2] = DATA_W'(hour_i);
  assign now[3] = DATA_W'(day_i);

  alarm_regs #(.NF(NFIELD), .DW(DATA_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .regs_o(regs)
  );

  alarm_cmp #(.NF(NFIELD), .DW(DATA_W)) i_cmp (
    .clk_i, .rst_ni, .regs_i(regs), .now_i(now), .mode_o(mode), .match_o(match)
  );

  alarm_pulse i_pulse (
    .clk_i, .rst_ni, .tick_i, .match_i(match), .irq_o
  );

  AST_IRQ_ONLY_FOR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(mode) == RPT_HOUR) |-> ($past(sec_i) == regs[0][6:0] || $past(wr_en_i))); // R8
endmodule

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic tick_i = 1'b0;
  logic [6:0] sec_i = '0;
  logic [6:0] min_i = '0;
  logic [5:0] hour_i = '0;
  logic [4:0] day_i = '0;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  rtc_alarm_match i_rtc_alarm_match (.*);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                      input logic [4:0] d, input logic exp, input string tag);
    exp_t e;
    @(negedge clk_i);
    sec_i = s; min_i = m; hour_i = h; day_i = d; tick_i = 1'b1;
    e.exp = exp; e.tag = tag;
    q.push_back(e);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // monitor: irq_o checked one clock after each edge
  initial begin
    forever begin
      logic t;
      exp_t e;
      @(posedge clk_i);
      t = tick_i;
      #1;
      if (rst_ni && !done) begin
        if (t) begin
          if (q.size() == 0) check(1'b0, "R12 empty queue", 0, 1);
          else begin
            e = q.pop_front();
            check(irq_o == e.exp, e.tag, irq_o, e.exp);
          end
        end else begin
          check(irq_o == 1'b0, "R12 idle", irq_o, 0);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    // R1
    #1 check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 8'h00, "R1 reg");

    // R2 / R3
    wr(0, 8'h45); rd_chk(0, 8'h45, "R2 sec store");
    wr(0, 8'h5A); rd_chk(0, 8'h45, "R3 sec units bad");
    wr(0, 8'h60); rd_chk(0, 8'h45, "R3 sec tens bad");
    wr(1, 8'h59); rd_chk(1, 8'h59, "R3 min 59 ok");
    wr(1, 8'h7F); rd_chk(1, 8'h59, "R3 min bad");
    wr(1, 8'hB0); rd_chk(1, 8'hB0, "R2 min with mask");
    // R4
    wr(2, 8'h23); rd_chk(2, 8'h23, "R4 hour 23 ok");
    wr(2, 8'h24); rd_chk(2, 8'h23, "R4 hour 24 bad");
    wr(2, 8'h1A); rd_chk(2, 8'h23, "R4 hour units bad");
    // R5
    wr(3, 8'h3F); rd_chk(3, 8'h3F, "R5 day any");
    rd_chk(0, 8'h45, "R2 sec readback");

    // R6 monthly
    wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h12); wr(3, 8'h07);
    tick(7'h30, 7'h15, 6'h12, 5'h07, 1'b1, "R6 full match");
    tick(7'h30, 7'h15, 6'h12, 5'h08, 1'b0, "R6 day differs");
    tick(7'h31, 7'h15, 6'h12, 5'h07, 1'b0, "R6 sec differs");
    tick(7'h30, 7'h15, 6'h13, 5'h07, 1'b0, "R6 hour differs");
    tick(7'h30, 7'h16, 6'h12, 5'h07, 1'b0, "R6 min differs");

    // R7 daily
    wr(3, 8'h87);
    tick(7'h30, 7'h15, 6'h12, 5'h09, 1'b1, "R7 day ignored");
    tick(7'h30, 7'h15, 6'h11, 5'h07, 1'b0, "R7 hour differs");

    // R8 hourly
    wr(2, 8'h92);
    tick(7'h30, 7'h15, 6'h05, 5'h01, 1'b1, "R8 hour ignored");
    tick(7'h30, 7'h44, 6'h12, 5'h07, 1'b0, "R8 min differs");

    // R9 minute
    wr(1, 8'h95);
    tick(7'h30, 7'h40, 6'h05, 5'h01, 1'b1, "R9 min ignored");
    tick(7'h29, 7'h15, 6'h12, 5'h07, 1'b0, "R9 sec differs");

    // R10 every second
    wr(0, 8'hB0);
    tick(7'h01, 7'h02, 6'h03, 5'h04, 1'b1, "R10 tick a");
    tick(7'h59, 7'h00, 6'h23, 5'h1F, 1'b1, "R10 tick b");

    // R11 mixed pattern: day+min masked, hour+sec not
    wr(0, 8'h30); wr(2, 8'h12);
    tick(7'h01, 7'h02, 6'h03, 5'h04, 1'b1, "R11 mixed a");
    tick(7'h45, 7'h33, 6'h21, 5'h11, 1'b1, "R11 mixed b");

    // R12 match created by a write, no tick: monitor expects no irq
    wr(3, 8'h07); wr(1, 8'h15);
    @(negedge clk_i); sec_i = 7'h30; min_i = 7'h15; hour_i = 6'h12; day_i = 5'h07;
    repeat (4) @(negedge clk_i);
    tick(7'h30, 7'h15, 6'h12, 5'h07, 1'b1, "R12 tick fires");
    repeat (3) @(negedge clk_i);

    done = 1;
    if (q.size() != 0) check(1'b0, "R12 leftover", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule